// File: doc/BRIEF.md
# Receive DMA Bus Request Generator

This block decides when a receive DMA engine asks for the shared bus, and which requester the bus goes to. It watches how many bytes are free in the receive FIFO. A normal receive request is raised once the FIFO holds enough data to fill a burst. When free space drops below a programmable low-water mark, an urgent request is raised instead. The urgent request skips the burst condition and beats every other requester, so the FIFO is drained before it overruns.

The low-water mark is held in an 8-bit host-writable register. Bits 4..0 give the mark in units of 32 bytes, and bits 7..5 always read zero. The burst size is given in bytes on an input port. Competing requesters share a fixed-priority arbiter with the receive path. The request, the urgent flag and a one-hot grant vector are registered, so they reflect the inputs and the register contents sampled at the previous rising clock edge.

Top module: `rxdma_req_gen`

## Requirements
- R1: After reset the threshold register reads 0x04 on `cfg_rd_data`, and `rx_req`, `rx_urgent` and `grant` are all zero.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data[4:0]`, and the new value is visible on `cfg_rd_data` after the clock edge. Bits 7..5 always read 0, whatever was written to them.
- R3: `rx_urgent` is 1 in the cycle after an edge at which `fifo_free` was less than the stored 5-bit field multiplied by 32.
- R4: `rx_urgent` is 0 in the cycle after an edge at which `fifo_free` was at or above the field times 32. This includes a field of 0, which never gives an urgent request.
- R5: With no urgent condition, `rx_req` is 1 exactly when the bytes held in the FIFO (FIFO_BYTES minus `fifo_free`, taken as 0 if `fifo_free` exceeds FIFO_BYTES) were at or above `burst_thresh`.
- R6: An urgent condition sets `rx_req` regardless of `burst_thresh`.
- R7: While `rx_urgent` is 1, `grant` equals 1 (bit 0, the receive path), even if other requesters are active.
- R8: With no urgent condition, the active `other_req[i]` with the lowest index i gets the grant, shown as `grant[i+1]`.
- R9: A normal receive request gets the grant (`grant[0]`) only when no `other_req` bit was set.
- R10: `grant` has at most one bit set, and it is all zeros exactly when nothing requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Host write strobe for the threshold register |
| cfg_wr_data | input | 8 | Host write data; bits 4..0 are used |
| cfg_rd_data | output | 8 | Current threshold register value; bits 7..5 read zero |
| fifo_free | input | FREE_W | Free bytes in the receive FIFO |
| burst_thresh | input | FREE_W | Bytes held in the FIFO that are needed for a normal request |
| other_req | input | N_OTHER | Competing bus requests; lower index has higher priority |
| rx_req | output | 1 | Registered receive DMA request |
| rx_urgent | output | 1 | Registered urgent flag |
| grant | output | N_OTHER+1 | Registered one-hot grant; bit 0 is the receive path, bit i+1 is other_req[i] |

## Verification
The assertions assume that the host write data and `other_req` are stable around the clock edge. They also assume that every grant decision is made from the inputs at the previous edge, with no holding of a grant across cycles. The stimulus changes inputs only one time unit after each rising edge and samples outputs after the next edge. The sweep covers every threshold field from 0 to 31 against every legal free-space value, with shifting burst sizes and requester patterns. It keeps `fifo_free` within the FIFO size, so the clamped case is never required to hold.

// File: rtl/rxdma_req_pkg.sv
package rxdma_req_pkg;
  localparam int unsigned THR_REG_W   = 8;
  localparam int unsigned THR_FIELD_W = 5;
  localparam int unsigned UNIT_LOG2   = 5;   // threshold unit is 32 bytes
  localparam int unsigned THR_BYTES_W = THR_FIELD_W + UNIT_LOG2;
  localparam logic [THR_REG_W-1:0] THR_RESET = 8'h04;
endpackage

// File: rtl/rxdma_urg_thr_reg.sv
module rxdma_urg_thr_reg
  import rxdma_req_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [THR_REG_W-1:0]   wr_data,
  output logic [THR_FIELD_W-1:0] thr_field,
  output logic [THR_REG_W-1:0]   rd_data
);
  localparam int unsigned RSVD_W = THR_REG_W - THR_FIELD_W;

  logic [THR_FIELD_W-1:0] thr_q;

  // clock-enabled storage of the live field only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RESET[THR_FIELD_W-1:0];
    end else if (wr_en) begin
      thr_q <= wr_data[THR_FIELD_W-1:0];
    end
  end

  assign thr_field = thr_q;
  assign rd_data   = {{RSVD_W{1'b0}}, thr_q};
endmodule

// File: rtl/rxdma_req_cond.sv
module rxdma_req_cond
  import rxdma_req_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 2048,
  parameter int unsigned FREE_W     = 12
) (
  input  logic [FREE_W-1:0]      fifo_free,
  input  logic [FREE_W-1:0]      burst_thresh,
  input  logic [THR_FIELD_W-1:0] thr_field,
  output logic                   urgent,
  output logic                   normal
);
  localparam int unsigned CMP_W = (FREE_W > THR_BYTES_W) ? FREE_W : THR_BYTES_W;
  localparam logic [FREE_W-1:0] CAP = FREE_W'(FIFO_BYTES);

  logic [CMP_W-1:0]  free_ext;
  logic [CMP_W-1:0]  thr_bytes;
  logic [FREE_W-1:0] held;

  always_comb begin
    free_ext  = CMP_W'(fifo_free);
    thr_bytes = CMP_W'({thr_field, {UNIT_LOG2{1'b0}}});
    urgent    = (free_ext < thr_bytes);
    held      = (fifo_free > CAP) ? '0 : (CAP - fifo_free);
    normal    = !urgent && (held >= burst_thresh);
  end
endmodule

// File: rtl/rxdma_prio_arb.sv
module rxdma_prio_arb #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] taken;

  generate
    for (genvar i = 0; i < N; i++) begin : g_slot
      if (i == 0) begin : g_first
        assign gnt[i]   = req[i];
        assign taken[i] = req[i];
      end else begin : g_rest
        assign gnt[i]   = req[i] & ~taken[i-1];
        assign taken[i] = taken[i-1] | req[i];
      end
    end
  endgenerate
endmodule

// File: rtl/rxdma_req_gen.sv
module rxdma_req_gen
  import rxdma_req_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 2048,
  parameter int unsigned N_OTHER    = 3,
  localparam int unsigned FREE_W    = $clog2(FIFO_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [7:0]           cfg_wr_data,
  output logic [7:0]           cfg_rd_data,
  input  logic [FREE_W-1:0]    fifo_free,
  input  logic [FREE_W-1:0]    burst_thresh,
  input  logic [N_OTHER-1:0]   other_req,
  output logic                 rx_req,
  output logic                 rx_urgent,
  output logic [N_OTHER:0]     grant
);
  localparam int unsigned NSLOT = N_OTHER + 2;

  logic [THR_FIELD_W-1:0] thr_field;
  logic                   urg_c, norm_c;
  logic [NSLOT-1:0]       slot_req, slot_gnt;

  logic                   req_d, urg_d;
  logic [N_OTHER:0]       gnt_d;
  logic                   req_q, urg_q;
  logic [N_OTHER:0]       gnt_q;

  rxdma_urg_thr_reg u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .thr_field (thr_field),
    .rd_data   (cfg_rd_data)
  );

  rxdma_req_cond #(
    .FIFO_BYTES (FIFO_BYTES),
    .FREE_W     (FREE_W)
  ) u_cond (
    .fifo_free    (fifo_free),
    .burst_thresh (burst_thresh),
    .thr_field    (thr_field),
    .urgent       (urg_c),
    .normal       (norm_c)
  );

  // slot order: urgent rx first, others by index, normal rx last
  assign slot_req = {norm_c, other_req, urg_c};

  rxdma_prio_arb #(.N(NSLOT)) u_arb (
    .req (slot_req),
    .gnt (slot_gnt)
  );

  always_comb begin
    urg_d = urg_c;
    req_d = urg_c | norm_c;
    gnt_d = {slot_gnt[N_OTHER:1], slot_gnt[0] | slot_gnt[NSLOT-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      urg_q <= 1'b0;
      gnt_q <= '0;
    end else begin
      req_q <= req_d;
      urg_q <= urg_d;
      gnt_q <= gnt_d;
    end
  end

  assign rx_req    = req_q;
  assign rx_urgent = urg_q;
  assign grant     = gnt_q;
endmodule

// File: rtl/rxdma_req_gen_chk.sv
module rxdma_req_gen_chk #(
  parameter int unsigned N_OTHER = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr_en,
  input logic [7:0]         cfg_wr_data,
  input logic [7:0]         cfg_rd_data,
  input logic [N_OTHER-1:0] other_req,
  input logic               rx_req,
  input logic               rx_urgent,
  input logic [N_OTHER:0]   grant
);
  assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (cfg_rd_data == ($past(cfg_wr_data) & 8'h1F)));

  assert_urgent_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_urgent |-> rx_req);

  assert_urgent_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_urgent |-> (grant == {{N_OTHER{1'b0}}, 1'b1}));

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_others_served_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|other_req) |=> (|grant));

  assert_rx_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant[0] |-> rx_req);
endmodule

bind rxdma_req_gen rxdma_req_gen_chk #(.N_OTHER(N_OTHER)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .other_req   (other_req),
  .rx_req      (rx_req),
  .rx_urgent   (rx_urgent),
  .grant       (grant)
);

// File: tb/rxdma_req_gen_tb.sv
module rxdma_req_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FB  = 256;
  localparam int NO  = 3;
  localparam int FW  = $clog2(FB + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [7:0]    cfg_wr_data;
  logic [7:0]    cfg_rd_data;
  logic [FW-1:0] fifo_free;
  logic [FW-1:0] burst_thresh;
  logic [NO-1:0] other_req;
  logic          rx_req, rx_urgent;
  logic [NO:0]   grant;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_req_gen #(.FIFO_BYTES(FB), .N_OTHER(NO)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_wr_en (cfg_wr_en), .cfg_wr_data (cfg_wr_data), .cfg_rd_data (cfg_rd_data),
    .fifo_free (fifo_free), .burst_thresh (burst_thresh), .other_req (other_req),
    .rx_req (rx_req), .rx_urgent (rx_urgent), .grant (grant)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    fifo_free = FW'(FB); burst_thresh = '0; other_req = '0;
    #(CLK_PERIOD*3);
    // R1: reset state
    chk("R1 rd", int'(cfg_rd_data), 32'h04);
    chk("R1 req", int'(rx_req), 0);
    chk("R1 urg", int'(rx_urgent), 0);
    chk("R1 grant", int'(grant), 0);
    @(negedge clk); rst_n = 1'b1;
    tick;
    chk("R1 rd after release", int'(cfg_rd_data), 32'h04);

    // R2: every write value, reserved bits read zero
    for (int w = 0; w < 256; w++) begin
      cfg_wr_en = 1'b1; cfg_wr_data = 8'(w);
      tick;
      cfg_wr_en = 1'b0;
      chk("R2 readback", int'(cfg_rd_data), w & 32'h1F);
    end

    // full sweep: every threshold field against every free level
    for (int t = 0; t < 32; t++) begin
      cfg_wr_en = 1'b1; cfg_wr_data = 8'(t | ((t * 7) << 5));
      tick;
      cfg_wr_en = 1'b0;
      for (int f = 0; f <= FB; f++) begin
        int bt, oth, held, eg;
        bit eu, en;
        bt   = (f * 37 + t * 11) % (FB + 1);
        oth  = (f % 2 == 0) ? ((f / 2 + t) % 8) : 0;
        fifo_free = FW'(f); burst_thresh = FW'(bt); other_req = NO'(oth);
        tick;
        held = FB - f;
        eu   = (f < t * 32);
        en   = !eu && (held >= bt);
        if (eu)              eg = 1;
        else if (oth & 1)    eg = 2;
        else if (oth & 2)    eg = 4;
        else if (oth & 4)    eg = 8;
        else if (en)         eg = 1;
        else                 eg = 0;
        if (eu) chk("R3 urgent set", int'(rx_urgent), 1);
        else    chk("R4 urgent clear", int'(rx_urgent), 0);
        if (eu) chk("R6 urgent forces req", int'(rx_req), 1);
        else    chk("R5 normal req", int'(rx_req), int'(en));
        if (eu)           chk("R7 urgent grant", int'(grant), eg);
        else if (oth != 0) chk("R8 fixed priority", int'(grant), eg);
        else if (en)      chk("R9 rx normal grant", int'(grant), eg);
        else              chk("R10 idle grant", int'(grant), eg);
      end
    end
    // R10: nothing requested at all
    cfg_wr_en = 1'b1; cfg_wr_data = 8'h00; tick; cfg_wr_en = 1'b0;
    fifo_free = FW'(FB); burst_thresh = FW'(1); other_req = '0;
    tick;
    chk("R10 no requests", int'(grant), 0);
    chk("R5 empty fifo no req", int'(rx_req), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule